// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is the internal DMA engine of a card host controller. Software builds a list of descriptors in memory, loads the address of the first one and issues a start. The engine reads each descriptor and checks that it owns it. It then moves the buffer the descriptor points at, either from memory into the transmit data FIFO or from the receive data FIFO into memory. When the buffer is done, it writes the descriptor's first word back with the ownership bit cleared. It then follows the link to the next descriptor and stops after the one marked last.

A descriptor is four 32-bit words. Word 0 carries the flags. Word 1 carries the buffer size in bytes in its low 16 bits. Word 2 is the buffer address. Word 3 is the link to the next descriptor. Completion and error events are collected in a 10-bit write-one-to-clear status register, and a single interrupt line reports whether any status bit is pending. Memory is reached through a single-outstanding request/acknowledge port. The FIFO side has a push port for transmit and a show-ahead pop port for receive.

Top module: `chain_dma`

## Requirements
- R1: After rst_n is released the engine is idle: busy, mem_req, fifo_push, fifo_pop and irq are 0 and status is 0.
- R2: A start pulse with enable high, in idle, begins by fetching descriptor words 0..3 at pointer+0, +4, +8 and +12. The pointer is loaded by base_we. A start while suspended or halted is ignored.
- R3: If word 0 bit 31 (owner) is 0, the engine sets status bits 4 (invalid descriptor), 5 (error summary) and 9 (abnormal summary). It then suspends with busy low, moving no data and writing nothing back, until enable is deasserted.
- R4: Word 1 bits [15:0] give the size in bytes, and a size of 0 means 65536 bytes. The engine moves ceil(size/4) 32-bit words starting at the word 2 address, stepping by 4.
- R5: With dir_tx high, memory words are pushed into the FIFO only while fifo_full is low. With dir_tx low, FIFO words are popped only while fifo_empty is low and are then written to memory, in order.
- R6: After a buffer completes, word 0 is written back to its descriptor with bit 31 cleared and every other bit unchanged.
- R7: After write-back the engine stops if word 0 bit 2 (last) is set. Otherwise it fetches next from word 3 if bit 4 (chain) is set, or from pointer+16 if it is not.
- R8: On write-back of a descriptor whose word 0 bit 1 is clear, a transmit sets status bit 0 when ie_tx is high and a receive sets status bit 1 when ie_rx is high. Each also sets bit 8 (normal summary). Nothing is set otherwise.
- R9: A memory error on a fetch or data access sets status bits 2, 5 and 9. The engine then writes word 0 back with bit 30 set (owner unchanged) and halts with busy low until enable is deasserted.
- R10: Status bits are cleared by writing 1 to them through sts_we and sts_wdata, and bits written with 0 are kept. irq is high exactly when any status bit is set.
- R11: soft_rst returns the engine to idle by the next clock and clears the descriptor pointer, so a following start without base_we fetches from address 0.
- R12: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous engine reset |
| enable | input | 1 | Engine enable; low releases suspend or halt |
| start | input | 1 | Start pulse, taken in idle |
| dir_tx | input | 1 | 1 memory to FIFO, 0 FIFO to memory, latched at start |
| base_we | input | 1 | Load the descriptor pointer |
| base_addr | input | AW | First descriptor address |
| ie_tx | input | 1 | Transmit completion enable |
| ie_rx | input | 1 | Receive completion enable |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 10 | Status bits to clear |
| status | output | 10 | Status register |
| irq | output | 1 | Any status bit pending |
| busy | output | 1 | Engine is walking the chain |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| fifo_push | output | 1 | Push fifo_wdata into the transmit FIFO |
| fifo_wdata | output | 32 | Transmit FIFO data |
| fifo_full | input | 1 | Transmit FIFO full |
| fifo_pop | output | 1 | Pop the receive FIFO |
| fifo_rdata | input | 32 | Receive FIFO head word |
| fifo_empty | input | 1 | Receive FIFO empty |

## Verification
The bench targets several corner cases:
- A zero size field. A design that reads it literally moves nothing or a single word, where 16384 words are due.
- A size that is not a multiple of four. A truncating word count drops the tail word.
- A chain that jumps backwards and a run of contiguous descriptors. The first shows an engine that ignores the link and walks sequentially; the second shows one that follows word 3 regardless of the chain bit.
- Completion with the interrupt-disable bit set, or with the enable input low. Either exposes an engine that raises status unconditionally.
- An unowned descriptor and an error response mid-buffer. These show an engine that keeps moving data, writes back the wrong word, or accepts a start while stopped.
- A soft reset followed by a start without a pointer load. An engine that keeps its old pointer fetches from the wrong address.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          enable,
  input  logic          start,
  input  logic          dir_tx,
  input  logic          base_we,
  input  logic [AW-1:0] base_addr,
  input  logic          ie_tx,
  input  logic          ie_rx,
  input  logic          sts_we,
  input  logic [9:0]    sts_wdata,
  output logic [9:0]    status,
  output logic          irq,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          fifo_push,
  output logic [31:0]   fifo_wdata,
  input  logic          fifo_full,
  output logic          fifo_pop,
  input  logic [31:0]   fifo_rdata,
  input  logic          fifo_empty
);
  localparam int SZW  = 16;
  localparam int WCW  = SZW - 1;
  localparam int MAXB = 1 << SZW;

  localparam int D_DIC = 1, D_LAST = 2, D_CHAIN = 4, D_ES = 30, D_OWN = 31;
  localparam int B_TX = 0, B_RX = 1, B_FBE = 2, B_DINV = 4, B_ES = 5, B_NIS = 8, B_AIS = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_RD, S_PUSH, S_POP, S_WR, S_WB, S_ERRWB, S_SUSP, S_HALT
  } st_t;

  st_t            st;
  logic [AW-1:0]  dptr, baddr, nxt;
  logic [1:0]     fidx;
  logic [31:0]    w0, dbuf;
  logic [WCW-1:0] wrem;
  logic           dir;
  logic [9:0]     sts, sts_set;
  logic [SZW:0]   nbytes;
  logic [WCW-1:0] nwords;

  wire ack_ok  = mem_ack && !mem_err;
  wire ack_bad = mem_ack && mem_err;

  assign nbytes = (mem_rdata[SZW-1:0] == '0) ? (SZW+1)'(MAXB) : {1'b0, mem_rdata[SZW-1:0]};
  assign nwords = WCW'((nbytes + (SZW+1)'(3)) >> 2);

  assign busy      = !(st inside {S_IDLE, S_SUSP, S_HALT});
  assign mem_req   = st inside {S_FETCH, S_RD, S_WR, S_WB, S_ERRWB};
  assign mem_we    = st inside {S_WR, S_WB, S_ERRWB};
  assign fifo_push = (st == S_PUSH) && !fifo_full;
  assign fifo_pop  = (st == S_POP) && !fifo_empty;
  assign fifo_wdata = dbuf;
  assign status    = sts;
  assign irq       = |sts;

  always_comb begin
    case (st)
      S_FETCH:    mem_addr = dptr + AW'({fidx, 2'b00});
      S_RD, S_WR: mem_addr = baddr;
      default:    mem_addr = dptr;
    endcase
    case (st)
      S_WR:    mem_wdata = dbuf;
      S_ERRWB: mem_wdata = w0 | (32'd1 << D_ES);
      default: mem_wdata = w0 & ~(32'd1 << D_OWN);
    endcase
  end

  always_comb begin
    sts_set = '0;
    if (!soft_rst) begin
      if (ack_bad && (st inside {S_FETCH, S_RD, S_WR, S_WB}))
        sts_set = sts_set | (10'd1 << B_FBE) | (10'd1 << B_ES) | (10'd1 << B_AIS);
      if (st == S_FETCH && fidx == 2'd0 && ack_ok && !mem_rdata[D_OWN])
        sts_set = sts_set | (10'd1 << B_DINV) | (10'd1 << B_ES) | (10'd1 << B_AIS);
      if (st == S_WB && ack_ok && !w0[D_DIC]) begin
        if (dir && ie_tx)  sts_set = sts_set | (10'd1 << B_TX) | (10'd1 << B_NIS);
        if (!dir && ie_rx) sts_set = sts_set | (10'd1 << B_RX) | (10'd1 << B_NIS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~(sts_we ? sts_wdata : 10'd0)) | sts_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dptr <= '0; baddr <= '0; nxt <= '0; fidx <= '0;
      w0 <= '0; dbuf <= '0; wrem <= '0; dir <= 1'b0;
    end else if (soft_rst) begin
      st <= S_IDLE; dptr <= '0; fidx <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (base_we) dptr <= base_addr;
          if (start && enable) begin
            st <= S_FETCH; fidx <= '0; dir <= dir_tx;
          end
        end
        S_FETCH: begin
          if (ack_bad) st <= S_ERRWB;
          else if (ack_ok) begin
            fidx <= fidx + 2'd1;
            case (fidx)
              2'd0: begin
                w0 <= mem_rdata;
                if (!mem_rdata[D_OWN]) st <= S_SUSP;
              end
              2'd1: wrem  <= nwords;
              2'd2: baddr <= mem_rdata[AW-1:0];
              default: begin
                nxt <= mem_rdata[AW-1:0];
                st  <= dir ? S_RD : S_POP;
              end
            endcase
          end
        end
        S_RD: begin
          if (ack_bad) st <= S_ERRWB;
          else if (ack_ok) begin dbuf <= mem_rdata; st <= S_PUSH; end
        end
        S_PUSH: begin
          if (!fifo_full) begin
            baddr <= baddr + AW'(4);
            wrem  <= wrem - WCW'(1);
            st    <= (wrem == WCW'(1)) ? S_WB : S_RD;
          end
        end
        S_POP: begin
          if (!fifo_empty) begin dbuf <= fifo_rdata; st <= S_WR; end
        end
        S_WR: begin
          if (ack_bad) st <= S_ERRWB;
          else if (ack_ok) begin
            baddr <= baddr + AW'(4);
            wrem  <= wrem - WCW'(1);
            st    <= (wrem == WCW'(1)) ? S_WB : S_POP;
          end
        end
        S_WB: begin
          if (ack_bad) st <= S_HALT;
          else if (ack_ok) begin
            if (w0[D_LAST]) st <= S_IDLE;
            else begin
              dptr <= w0[D_CHAIN] ? nxt : dptr + AW'(16);
              fidx <= '0;
              st   <= S_FETCH;
            end
          end
        end
        S_ERRWB: if (mem_ack) st <= S_HALT;
        S_SUSP, S_HALT: begin
          if (base_we) dptr <= base_addr;
          if (!enable) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r11_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && !mem_req);

  a_r9_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_FBE]) |-> sts[B_AIS] && sts[B_ES]);

  a_r3_susp_quiet: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(sts[B_DINV]) |-> !busy && !fifo_push && !fifo_pop);

  a_r8_tx_norm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_TX]) |-> sts[B_NIS] && dir);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == S_IDLE) && start && enable |=> busy && mem_req && !mem_we);
endmodule

// File: tb/chain_dma_test.sv
module chain_dma_test;
  localparam int AW = 32;
  localparam logic [31:0] OWN = 32'h8000_0000, ES = 32'h4000_0000;
  localparam logic [31:0] CHN = 32'h10, FST = 32'h8, LST = 32'h4, DIC = 32'h2;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, enable = 1'b1, start = 1'b0, dir_tx = 1'b1;
  logic base_we = 1'b0, ie_tx = 1'b1, ie_rx = 1'b1, sts_we = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [9:0] sts_wdata = '0, status;
  logic irq, busy, mem_req, mem_we, fifo_push, fifo_pop;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, fifo_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0, fifo_full = 1'b0, fifo_empty = 1'b1;
  logic [31:0] mem_rdata = '0, fifo_rdata = '0;

  chain_dma #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable), .start(start),
    .dir_tx(dir_tx), .base_we(base_we), .base_addr(base_addr), .ie_tx(ie_tx), .ie_rx(ie_rx),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .status(status), .irq(irq), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty));

  always #5 clk = ~clk;

  int unsigned mem [int unsigned];
  logic [31:0] txq[$], rxq[$], expq[$];
  int compared = 0, mismatched = 0, cyc = 0, wcnt = 0, lat = 1;
  logic stall = 1'b0, pop_seen = 1'b0, cap_first = 1'b0, got_first = 1'b0;
  logic [AW-1:0] first_addr = '0, err_addr = 32'hFFFF_FFF0;
  bit done = 0;

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0; wcnt = 0;
    end else if (mem_req && rst_n && !soft_rst) begin
      if (cap_first && !got_first) begin first_addr = mem_addr; got_first = 1'b1; end
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_addr == err_addr) mem_err = 1'b1;
        else if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
      end else wcnt++;
    end
    if (pop_seen) void'(rxq.pop_front());
    fifo_rdata = (rxq.size() != 0) ? rxq[0] : 32'h0;
    fifo_empty = (rxq.size() == 0) || (stall && (cyc % 3 == 1));
    fifo_full  = stall && (cyc % 3 == 0);
    #1;
    pop_seen = fifo_pop;
    if (fifo_push) txq.push_back(fifo_wdata);
    chk("R10 irq tracks status", irq, |status);
    if (fifo_push && fifo_full) chk("R5 push while full", 1, 0);
    if (fifo_pop && fifo_empty) chk("R5 pop while empty", 1, 0);
    if (cyc > 190000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic put_desc(logic [31:0] a, logic [31:0] w0, logic [31:0] sz, logic [31:0] b, logic [31:0] n);
    mem[a] = w0; mem[a+4] = sz; mem[a+8] = b; mem[a+12] = n;
  endtask

  task automatic kick(logic load, logic [AW-1:0] a);
    @(negedge clk); base_we = load; base_addr = a; start = 1'b1;
    @(negedge clk); base_we = 1'b0; start = 1'b0;
  endtask

  task automatic run(logic [AW-1:0] a);
    kick(1'b1, a);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clr(logic [9:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0; sts_wdata = '0;
    @(negedge clk);
  endtask

  task automatic unstick();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic cmp_tx(string req);
    int bad = 0;
    if (txq.size() != expq.size()) bad++;
    else for (int i = 0; i < expq.size(); i++) if (txq[i] != expq[i]) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 fifo", {fifo_push, fifo_pop}, 0);

    // R2 R4 R6 R7: backward chain, odd size, FIFO stalls
    stall = 1'b1; lat = 1; dir_tx = 1'b1;
    put_desc(32'h1000, OWN|FST|CHN|DIC, 8, 32'h4000, 32'h2040);
    put_desc(32'h2040, OWN|CHN|DIC, 6, 32'h5000, 32'h1800);
    put_desc(32'h1800, OWN|CHN|LST, 4, 32'h6000, 0);
    expq = '{rd(32'h4000), rd(32'h4004), rd(32'h5000), rd(32'h5004), rd(32'h6000)};
    txq.delete(); cap_first = 1'b1; got_first = 1'b0;
    run(32'h1000);
    cap_first = 1'b0;
    chk("R2 first fetch address", first_addr, 32'h1000);
    cmp_tx("R4 R7 chained transmit data");
    chk("R6 writeback A", mem[32'h1000], FST|CHN|DIC);
    chk("R6 writeback B", mem[32'h2040], CHN|DIC);
    chk("R6 writeback C", mem[32'h1800], CHN|LST);
    chk("R8 tx completion status", status, 10'h101);

    // R10 write-one-to-clear
    clr(10'h001);
    chk("R10 partial clear", status, 10'h100);
    chk("R10 irq still set", irq, 1);
    clr(10'h100);
    chk("R10 full clear", status, 0);
    chk("R10 irq cleared", irq, 0);

    // R5 R7: receive, contiguous descriptors without chain bit
    dir_tx = 1'b0;
    put_desc(32'h3000, OWN|FST, 12, 32'h7000, 32'hDEAD_0000);
    put_desc(32'h3010, OWN|LST, 5, 32'h7100, 0);
    rxq.delete();
    for (int i = 0; i < 5; i++) rxq.push_back(32'h1111_0000 + i);
    run(32'h3000);
    chk("R5 rx word0", mem[32'h7000], 32'h1111_0000);
    chk("R5 rx word1", mem[32'h7004], 32'h1111_0001);
    chk("R5 rx word2", mem[32'h7008], 32'h1111_0002);
    chk("R7 sequential next word0", mem[32'h7100], 32'h1111_0003);
    chk("R4 rx tail word", mem[32'h7104], 32'h1111_0004);
    chk("R6 rx writeback", mem[32'h3010], LST);
    chk("R8 rx completion status", status, 10'h102);
    clr(status);

    // R8: receive completion with enable low
    ie_rx = 1'b0;
    put_desc(32'h3100, OWN|LST, 4, 32'h7200, 0);
    rxq.push_back(32'h2222_0000);
    run(32'h3100);
    chk("R8 rx disabled status", status, 0);
    chk("R5 rx data", mem[32'h7200], 32'h2222_0000);
    ie_rx = 1'b1;

    // R8: interrupt-disable descriptor bit
    dir_tx = 1'b1; txq.delete();
    put_desc(32'h3200, OWN|LST|DIC, 4, 32'h7300, 0);
    run(32'h3200);
    chk("R8 dic suppresses status", status, 0);
    chk("R4 one word moved", txq.size(), 1);

    // R3: unowned descriptor
    txq.delete();
    put_desc(32'h3300, LST, 8, 32'h7400, 0);
    run(32'h3300);
    chk("R3 invalid descriptor status", status, 10'h230);
    chk("R3 no data moved", txq.size(), 0);
    chk("R3 no writeback", mem[32'h3300], LST);
    chk("R3 suspended not busy", busy, 0);
    kick(1'b0, '0);
    chk("R2 start ignored while suspended", busy, 0);
    unstick(); clr(status);

    // R4: zero size means 65536 bytes
    stall = 1'b0; lat = 0; txq.delete(); expq.delete();
    put_desc(32'h3400, OWN|LST, 0, 32'h0010_0000, 0);
    for (int i = 0; i < 16384; i++) expq.push_back(rd(32'h0010_0000 + 4*i));
    run(32'h3400);
    cmp_tx("R4 zero size moves 16384 words");
    chk("R8 status after max buffer", status, 10'h101);
    clr(status);

    // R9: bus error mid-buffer
    lat = 1; txq.delete(); err_addr = 32'h8008;
    put_desc(32'h3500, OWN|LST, 16, 32'h8000, 0);
    run(32'h3500);
    err_addr = 32'hFFFF_FFF0;
    chk("R9 error status", status, 10'h224);
    chk("R9 words before error", txq.size(), 2);
    chk("R9 error summary written", mem[32'h3500], OWN|LST|ES);
    kick(1'b0, '0);
    @(negedge clk);
    chk("R2 start ignored while halted", {busy, mem_req}, 0);
    unstick(); clr(status);

    // R11: soft reset mid-transfer, then start from pointer 0
    put_desc(32'h3600, OWN|LST, 0, 32'h0020_0000, 0);
    mem[0] = 32'h0;
    kick(1'b1, 32'h3600);
    repeat (40) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R11 idle after soft reset", {busy, mem_req}, 0);
    clr(status);
    cap_first = 1'b1; got_first = 1'b0;
    kick(1'b0, '0);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R11 pointer cleared", first_addr, 0);
    chk("R11 R3 fetch at zero unowned", status, 10'h230);
    unstick();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule